// File: doc/BRIEF.md
# Codec Serial Port with Register Slot

This block is the converter side of a synchronous serial audio link. It derives a serial bit clock and a frame marker from the master clock and exchanges one 16-bit sample word per frame with a host. The host receives the ADC sample on `dout` and sends the DAC sample on `din`. The bit clock divider and the frame divider are both programmable.

Each frame also has a second 16-bit slot, which starts halfway through the frame. The host uses it to read or write a small bank of 8-bit configuration registers. The slot is only live when the host asks for it. It can ask by holding the hardware request pin high, or by setting bit 0 of its sample word when full 16-bit sample mode is off. A read returns the register byte within the same slot.

Top module: `codec_serial_port`

## Requirements
- R1: `sclk` has a period of 2×D master-clock cycles. D is the value of register 2, and a value of 0 counts as 1. A new value takes effect at the next frame start.
- R2: A frame lasts F×256 master-clock cycles, which is F×128/D bit-clock periods. F is register 3, and 0 counts as 1. `fs` is high for exactly the first bit period of the sample slot (period 0) and of the register slot (period equal to half the frame length). It is low in every other period.
- R3: In the sample slot, `dout` carries the ADC word MSB first, taken at the frame start. `dout` changes only when `sclk` rises, and `din` is sampled when `sclk` falls.
- R4: After the 16th sample bit, `dac_sample` is updated and `dac_valid` pulses for one master-clock cycle. When 16-bit mode (register 1 bit 2) is set, the whole input word is passed through. When it is clear, bit 0 of `dac_sample` is forced to 0.
- R5: The register slot is enabled for a frame when `fc_req` is high at the last falling edge of the sample slot. It is also enabled when bit 0 of the input sample word is 1 while 16-bit mode is off. While 16-bit mode is on, that bit has no effect.
- R6: The host's register-slot word is decoded as follows. Bits 15 and 14 are ignored. Bit 13 selects read (1) or write (0). Bits 12 to 8 give the register address and bits 7 to 0 the data. A write lands at the last falling edge of the slot.
- R7: On an enabled read, `dout` shows 8 zeros followed by the addressed register byte, MSB first.
- R8: In a frame with no request, the register slot output is all zeros and no register changes.
- R9: Only addresses 0 to 7 hold registers. Addresses 8 to 31 read as zero and ignore writes.
- R10: Reset clears all registers. 16-bit mode is therefore off and both dividers act as 1, giving a 2-cycle bit clock and 128 bit periods per frame. All outputs are low while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fc_req | input | 1 | Hardware request for the register slot |
| din | input | 1 | Serial data from host |
| adc_sample | input | 16 | Converter sample to be sent |
| sclk | output | 1 | Serial bit clock |
| fs | output | 1 | Slot start marker |
| dout | output | 1 | Serial data to host |
| dac_sample | output | 16 | Last received sample word |
| dac_valid | output | 1 | One-cycle strobe when `dac_sample` updates |

## Verification
The bench moves the bit clock divider to 4, which makes a 32-period frame. The register slot then follows the sample slot with no gap. A design that placed the slot from a stale frame length would put `fs` in the wrong period or drop bits. The bench sets bit 0 of the sample word while 16-bit mode is on. A design that still honoured the flag would return read data or commit a write it should not. The bench also writes and reads an unimplemented address, which catches aliasing onto a real register. Random frames reprogram both dividers and the mode while checking that each change waits for the frame boundary.

// File: rtl/csp_pkg.sv
package csp_pkg;
  localparam int WORD_W     = 16;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 8;
  localparam int POS_W      = 16;
  localparam int DIV_W      = 8;
  localparam int FRAME_UNIT = 128;  // bit periods per frame step at unit bit divider
  localparam int REG_CTRL   = 1;
  localparam int REG_SDIV   = 2;
  localparam int REG_FDIV   = 3;
  localparam int MODE16_BIT = 2;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } reg_cmd_t;

  // zero in a divider register behaves as one
  function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] v);
    return (v == '0) ? DIV_W'(1) : v;
  endfunction

  // bit periods per frame for effective frame and bit dividers
  function automatic logic [POS_W-1:0] frame_periods(input logic [DIV_W-1:0] fk,
                                                     input logic [DIV_W-1:0] sd);
    logic [POS_W-1:0] num;
    num = POS_W'(fk) * POS_W'(FRAME_UNIT);
    return num / POS_W'(sd);
  endfunction
endpackage

// File: rtl/csp_sclk_gen.sv
module csp_sclk_gen
  import csp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_div,
  output logic             sclk,
  output logic             rise_evt,
  output logic             fall_evt
);
  logic [DIV_W-1:0] cnt;
  logic             tick;

  assign tick     = (cnt == half_div - 1'b1);
  assign rise_evt = tick & ~sclk;
  assign fall_evt = tick & sclk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (tick) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/csp_framer.sv
module csp_framer
  import csp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_evt,
  input  logic [POS_W-1:0] frame_len,
  output logic [POS_W-1:0] pos,
  output logic [POS_W-1:0] nxt_pos,
  output logic [POS_W-1:0] half,
  output logic             wrap,
  output logic             fs
);
  localparam logic [POS_W-1:0] POS_RST = frame_periods(DIV_W'(1), DIV_W'(1)) - 1'b1;

  assign half    = frame_len >> 1;
  assign wrap    = (pos == frame_len - 1'b1);
  assign nxt_pos = wrap ? '0 : pos + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= POS_RST;
      fs  <= 1'b0;
    end else if (rise_evt) begin
      pos <= nxt_pos;
      fs  <= (nxt_pos == '0) || (nxt_pos == half);
    end
  end
endmodule

// File: rtl/csp_shifter.sv
module csp_shifter
  import csp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_evt,
  input  logic              fall_evt,
  input  logic [POS_W-1:0]  pos,
  input  logic [POS_W-1:0]  nxt_pos,
  input  logic [POS_W-1:0]  half,
  input  logic              din,
  input  logic [WORD_W-1:0] adc_sample,
  input  logic              mode16,
  input  logic              fc_req,
  input  logic [DATA_W-1:0] rd_data,
  output logic              dout,
  output logic [WORD_W-1:0] dac_sample,
  output logic              dac_valid,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              sec_active,
  output logic              sec_hi_phase
);
  localparam logic [POS_W-1:0] SLOT_LEN  = POS_W'(WORD_W);
  localparam logic [POS_W-1:0] SLOT_LAST = POS_W'(WORD_W - 1);
  localparam logic [POS_W-1:0] DATA_OFF  = POS_W'(WORD_W - DATA_W);

  logic [WORD_W-1:0] tx;
  logic [WORD_W-2:0] rx;
  logic [WORD_W-1:0] full_word;
  logic [POS_W-1:0]  nxt_off, cur_off;
  logic              nxt_in_pri, nxt_in_sec, cur_in_pri, cur_in_sec;
  logic              pri_done, sec_done, rd_req;
  reg_cmd_t          cmd;

  assign nxt_off    = nxt_pos - half;
  assign cur_off    = pos - half;
  assign nxt_in_pri = nxt_pos < SLOT_LEN;
  assign cur_in_pri = pos < SLOT_LEN;
  assign nxt_in_sec = (nxt_pos >= half) && (nxt_off < SLOT_LEN);
  assign cur_in_sec = (pos >= half) && (cur_off < SLOT_LEN);

  assign full_word    = {rx, din};
  assign cmd          = reg_cmd_t'(full_word[ADDR_W+DATA_W:0]);
  assign pri_done     = fall_evt && (pos == SLOT_LAST);
  assign sec_done     = fall_evt && cur_in_sec && (cur_off == SLOT_LAST);
  assign wr_en        = sec_done && sec_active && !cmd.rd;
  assign wr_addr      = cmd.addr;
  assign wr_data      = cmd.data;
  // after the first half of the slot the low received bits hold rw and address
  assign rd_addr      = rx[ADDR_W-1:0];
  assign rd_req       = sec_active && rx[ADDR_W];
  assign sec_hi_phase = cur_in_sec && (cur_off < DATA_OFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx         <= '0;
      rx         <= '0;
      dout       <= 1'b0;
      dac_sample <= '0;
      dac_valid  <= 1'b0;
      sec_active <= 1'b0;
    end else begin
      dac_valid <= pri_done;
      if (rise_evt) begin
        if (nxt_pos == '0) begin
          dout       <= adc_sample[WORD_W-1];
          tx         <= {adc_sample[WORD_W-2:0], 1'b0};
          sec_active <= 1'b0;
        end else if (nxt_in_pri) begin
          dout <= tx[WORD_W-1];
          tx   <= tx << 1;
        end else if (nxt_in_sec && nxt_off == DATA_OFF) begin
          dout <= rd_req ? rd_data[DATA_W-1] : 1'b0;
          tx   <= rd_req ? {rd_data[DATA_W-2:0], {(WORD_W-DATA_W+1){1'b0}}} : '0;
        end else if (nxt_in_sec && nxt_off > DATA_OFF) begin
          dout <= tx[WORD_W-1];
          tx   <= tx << 1;
        end else begin
          dout <= 1'b0;
        end
      end
      if (fall_evt && (cur_in_pri || cur_in_sec)) begin
        rx <= full_word[WORD_W-2:0];
      end
      if (pri_done) begin
        dac_sample <= mode16 ? full_word : {full_word[WORD_W-1:1], 1'b0};
        sec_active <= fc_req | (~mode16 & din);
      end
    end
  end
endmodule

// File: rtl/csp_regfile.sv
module csp_regfile
  import csp_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              mode16,
  output logic [DIV_W-1:0]  sclk_div,
  output logic [DIV_W-1:0]  frame_div
);
  localparam int IDX_W = $clog2(NUM_REGS);

  logic [DATA_W-1:0] regs [NUM_REGS];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REGS; i++) begin
      if (!rst_n) regs[i] <= '0;
      else if (wr_en && int'(wr_addr) == i) regs[i] <= wr_data;
    end
  end

  assign rd_data   = (int'(rd_addr) < NUM_REGS) ? regs[rd_addr[IDX_W-1:0]] : '0;
  assign mode16    = regs[REG_CTRL][MODE16_BIT];
  assign sclk_div  = regs[REG_SDIV];
  assign frame_div = regs[REG_FDIV];
endmodule

// File: rtl/codec_serial_port.sv
module codec_serial_port
  import csp_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic        mclk,
  input  logic        rst_n,
  input  logic        fc_req,
  input  logic        din,
  input  logic [15:0] adc_sample,
  output logic        sclk,
  output logic        fs,
  output logic        dout,
  output logic [15:0] dac_sample,
  output logic        dac_valid
);
  logic             rise_evt, fall_evt, wrap;
  logic [POS_W-1:0] pos, nxt_pos, half, len_q;
  logic [DIV_W-1:0] sdiv_raw, fdiv_raw, sdiv_q;
  logic             mode16, wr_en, sec_active, sec_hi_phase;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;

  // divider settings move only at a frame boundary
  always_ff @(posedge mclk) begin
    if (!rst_n) begin
      sdiv_q <= eff_div('0);
      len_q  <= frame_periods(eff_div('0), eff_div('0));
    end else if (rise_evt && wrap) begin
      sdiv_q <= eff_div(sdiv_raw);
      len_q  <= frame_periods(eff_div(fdiv_raw), eff_div(sdiv_raw));
    end
  end

  csp_sclk_gen u_clk (
    .clk(mclk), .rst_n(rst_n), .half_div(sdiv_q),
    .sclk(sclk), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  csp_framer u_frm (
    .clk(mclk), .rst_n(rst_n), .rise_evt(rise_evt), .frame_len(len_q),
    .pos(pos), .nxt_pos(nxt_pos), .half(half), .wrap(wrap), .fs(fs)
  );

  csp_shifter u_shf (
    .clk(mclk), .rst_n(rst_n), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .pos(pos), .nxt_pos(nxt_pos), .half(half), .din(din),
    .adc_sample(adc_sample), .mode16(mode16), .fc_req(fc_req), .rd_data(rd_data),
    .dout(dout), .dac_sample(dac_sample), .dac_valid(dac_valid),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .sec_active(sec_active), .sec_hi_phase(sec_hi_phase)
  );

  csp_regfile #(.NUM_REGS(NUM_REGS)) u_reg (
    .clk(mclk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .mode16(mode16),
    .sclk_div(sdiv_raw), .frame_div(fdiv_raw)
  );
endmodule

// File: rtl/csp_checker.sv
module csp_checker #(
  parameter int NUM_REGS = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        sclk,
  input logic        fs,
  input logic        dout,
  input logic        dac_valid,
  input logic        rise_evt,
  input logic        fall_evt,
  input logic [15:0] pos,
  input logic        wr_en,
  input logic        sec_active,
  input logic        sec_hi_phase,
  input logic [4:0]  rd_addr,
  input logic [7:0]  rd_data
);
  a_r1_sclk_moves_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk != $past(sclk)) |-> ($past(rise_evt) || $past(fall_evt)));

  a_r2_fs_starts_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fs) |-> $past(rise_evt));

  a_r3_dout_held_between_rises: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rise_evt) |-> $stable(dout));

  a_r4_valid_after_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid |-> ($past(fall_evt) && $past(pos) == 16'd15));

  a_r7_upper_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sec_hi_phase |-> !dout);

  a_r8_write_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> sec_active);

  a_r9_unimplemented_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_addr) >= NUM_REGS) |-> (rd_data == 8'h00));
endmodule

bind codec_serial_port csp_checker #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(mclk), .rst_n(rst_n), .sclk(sclk), .fs(fs), .dout(dout),
  .dac_valid(dac_valid), .rise_evt(rise_evt), .fall_evt(fall_evt), .pos(pos),
  .wr_en(wr_en), .sec_active(sec_active), .sec_hi_phase(sec_hi_phase),
  .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/codec_serial_port_test.sv
module codec_serial_port_test;
  logic        mclk = 1'b0, rst_n = 1'b0, fc_req = 1'b0, din = 1'b0;
  logic [15:0] adc_sample = '0;
  logic        sclk, fs, dout, dac_valid;
  logic [15:0] dac_sample;

  int  total = 0, bad = 0, mcnt = 0, mark = 0, gap = 0;
  bit  done = 0;
  logic [7:0] mdl [32];

  codec_serial_port uut (
    .mclk(mclk), .rst_n(rst_n), .fc_req(fc_req), .din(din), .adc_sample(adc_sample),
    .sclk(sclk), .fs(fs), .dout(dout), .dac_sample(dac_sample), .dac_valid(dac_valid)
  );

  always #5 mclk = ~mclk;
  always @(posedge mclk) mcnt++;
  always @(posedge sclk) begin gap = mcnt - mark; mark = mcnt; end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int eff(input logic [7:0] v);
    return (v == 8'h00) ? 1 : int'(v);
  endfunction

  // master cycles per frame divided by master cycles per bit period
  function automatic int bits_per_frame();
    return (eff(mdl[3]) * 256) / (2 * eff(mdl[2]));
  endfunction

  function automatic logic [7:0] model_rd(input logic [4:0] a);
    return (a < 5'd8) ? mdl[a] : 8'h00;
  endfunction

  function automatic logic [15:0] wr_word(input logic [4:0] a, input logic [7:0] d);
    return {2'($urandom), 1'b0, a, d};
  endfunction

  function automatic logic [15:0] rd_word(input logic [4:0] a);
    return {2'($urandom), 1'b1, a, 8'($urandom)};
  endfunction

  task automatic run_frame(input logic [15:0] adc, input logic [15:0] pri,
                           input logic fc, input logic [15:0] sec, input string tag);
    logic [15:0] po, so, exp_sec, exp_dac;
    logic        m16, req;
    bit          fs_ok;
    int          len, hf, sd;
    len = bits_per_frame(); hf = len / 2; sd = eff(mdl[2]);
    m16 = mdl[1][2];
    req = fc | (!m16 & pri[0]);
    exp_sec = (req && sec[13]) ? {8'h00, model_rd(sec[12:8])} : 16'h0000;
    exp_dac = m16 ? pri : {pri[15:1], 1'b0};
    po = '0; so = '0; fs_ok = 1;
    adc_sample = adc; fc_req = fc;
    for (int p = 0; p < len; p++) begin
      @(posedge sclk); #1;
      if (fs !== ((p == 0) || (p == hf))) fs_ok = 0;
      if (p == 1) chk({"R1 bit clock period ", tag}, gap, 2 * sd);
      if (p < 16) din = pri[15-p];
      else if (p >= hf && p < hf + 16) din = sec[15-(p-hf)];
      else din = 1'b0;
      @(negedge sclk); #1;
      if (p < 16) po[15-p] = dout;
      else if (p >= hf && p < hf + 16) so[15-(p-hf)] = dout;
    end
    fc_req = 1'b0;
    chk({"R2 fs placement ", tag}, fs_ok, 1);
    chk({"R3 adc word ", tag}, po, adc);
    chk({"R4 dac word ", tag}, dac_sample, exp_dac);
    if (!req) chk({"R8 idle slot ", tag}, so, 16'h0000);
    else if (sec[13]) chk({"R7 read slot ", tag}, so, exp_sec);
    else chk({"R6 write slot ", tag}, so, 16'h0000);
    if (req && !sec[13] && sec[12:8] < 5'd8) mdl[sec[12:8]] = sec[7:0];
  endtask

  initial begin
    #1_900_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] sec;
    logic [4:0]  a;
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
    repeat (4) @(posedge mclk); #1;
    chk("R10 sclk in reset", sclk, 0);
    chk("R10 fs in reset", fs, 0);
    chk("R10 dout in reset", dout, 0);
    chk("R10 dac in reset", dac_sample, 0);
    chk("R10 valid in reset", dac_valid, 0);
    rst_n = 1'b1;

    run_frame(16'h8001, 16'h1234, 1'b0, rd_word(5'd4), "R10 default frame");
    run_frame(16'hBEEF, 16'h0F0E, 1'b1, wr_word(5'd4, 8'hA5), "hw write");
    run_frame(16'h0001, 16'hA5A5, 1'b0, rd_word(5'd4), "R5 sw flag read");
    run_frame(16'h7F00, 16'h2222, 1'b1, wr_word(5'd20, 8'hFF), "R9 write hole");
    run_frame(16'h00FF, 16'h3333, 1'b1, rd_word(5'd20), "R9 read hole");
    run_frame(16'h5555, 16'h4444, 1'b1, wr_word(5'd1, 8'h04), "R4 enter 16-bit");
    run_frame(16'hAAAA, 16'h7777, 1'b0, wr_word(5'd5, 8'h3C), "R5 flag ignored");
    run_frame(16'h1357, 16'h8888, 1'b1, rd_word(5'd5), "R5 no stray write");
    run_frame(16'h2468, 16'h9998, 1'b1, wr_word(5'd2, 8'h04), "R1 set div 4");
    run_frame(16'hFEDC, 16'hABCD, 1'b1, rd_word(5'd2), "R2 short frame");
    run_frame(16'h0F0F, 16'h1111, 1'b1, wr_word(5'd3, 8'h02), "R2 set frame div");
    run_frame(16'hF0F0, 16'h1110, 1'b0, rd_word(5'd3), "R2 longer frame");
    run_frame(16'h0000, 16'h5556, 1'b1, wr_word(5'd1, 8'h00), "R4 leave 16-bit");

    for (int n = 0; n < 100; n++) begin
      a = 5'($urandom);
      if ($urandom % 2 == 0) sec = rd_word(a);
      else begin
        sec = wr_word(a, 8'($urandom));
        if (a == 5'd2) sec[7:0] = 8'(1 << ($urandom % 3));
        if (a == 5'd3) sec[7:0] = 8'($urandom % 3);
      end
      run_frame(16'($urandom), 16'($urandom), 1'($urandom), sec, "random");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule